// File: doc/BRIEF.md
# Q31 Saturating Add/Subtract Unit

This block performs signed fractional arithmetic on 32-bit Q31 operands, clamping every result to the representable range. The 2-bit opcode chooses one of four operations: plain saturating add, plain saturating subtract, and two doubling forms. A doubling form first multiplies the second operand by two with its own saturation, then adds it to or subtracts it from the first operand with a second saturation. The doubling forms let a caller turn the 48-bit-aligned product of a 32x16 multiply into a Q31 value and accumulate it in one step. The per-operation opcode selects saturation; the block keeps no mode state.

The result and a same-cycle "saturation occurred" indication are combinational from the operands. One sticky status bit gathers every clamp that occurs on an issued operation. It stays set until a clear request removes it.

Top module: `q31_satalu`

## Requirements
- R1: With opcode 2'b00, `result` equals a+b, computed in full precision and then clamped to the signed 32-bit range.
- R2: With opcode 2'b01, `result` equals a-b, computed in full precision and then clamped.
- R3: With opcode 2'b10, `result` equals a + D, clamped, where D is 2*b clamped to the signed 32-bit range.
- R4: With opcode 2'b11, `result` equals a - D, clamped, with D defined as in R3.
- R5: A positive overflow yields 32'h7FFFFFFF and a negative overflow yields 32'h80000000.
- R6: Doubling 32'h80000000 gives 32'h80000000 and doubling 32'h40000000 gives 32'h7FFFFFFF. Either case counts as a clamp even when the final add does not overflow.
- R7: `sat_hit` is high in the same cycle exactly when the doubling stage or the final stage clamps.
- R8: At a rising clock edge where `issue` and `sat_hit` are high and `sticky_clr` is low, `q_sticky` becomes 1. It then stays 1 until it is cleared.
- R9: At a rising edge where `sticky_clr` is high, `q_sticky` becomes 0. This clear takes priority over a set in the same cycle.
- R10: A clamp while `issue` is low leaves `q_sticky` unchanged.
- R11: While `rst_n` is low at a rising edge, `q_sticky` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Operation present this cycle; qualifies the sticky update |
| opcode | input | 2 | 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| opa | input | 32 | First operand, signed Q31 |
| opb | input | 32 | Second operand, signed Q31 (doubled in the doubling forms) |
| sticky_clr | input | 1 | Clears the sticky bit at the next edge |
| result | output | 32 | Saturated result |
| sat_hit | output | 1 | A clamp occurred in this cycle's operation |
| q_sticky | output | 1 | Sticky record of clamps on issued operations |

## Verification
The hardest case is a clamp in the doubling stage that the final stage does not show. An example is adding a large negative first operand to the clamped double of 32'h40000000. In this case only `sat_hit` shows that the clamp occurred. The stimulus crosses every operation with a set of boundary operands: both extremes, their neighbours, plus and minus one half, zero, and minus one. This produces such cases on purpose. Random operands add thousands more. The sticky bit is driven through set, hold, clear-against-set and un-issued-clamp sequences, so each edge rule is observed at the port.

// File: rtl/q31_pkg.sv
// Shared definitions for the Q31 saturating unit.
// Assumes two's complement operands; opcode bit 1 selects doubling,
// opcode bit 0 selects subtraction.
package q31_pkg;
    localparam int Q31_W = 32;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } q31_op_e;
endpackage

// File: rtl/q31_sat_doubler.sv
// Saturating doubler: returns 2*x clamped to the signed WIDTH range.
// Assumes WIDTH >= 2. Combinational, no state.
module q31_sat_doubler #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             clamped
);
    localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

    // Overflow when the two top bits disagree; pick the bound by sign.
    always_comb begin
        clamped = din[WIDTH-1] ^ din[WIDTH-2];
        if (clamped)
            dout = din[WIDTH-1] ? MINV : MAXV;
        else
            dout = {din[WIDTH-2:0], 1'b0};
    end
endmodule

// File: rtl/q31_sat_addsub.sv
// Saturating adder/subtractor on signed WIDTH operands.
// Computes in WIDTH+1 bits and clamps when the top two bits disagree.
module q31_sat_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             clamped
);
    localparam int EXT = WIDTH + 1;
    localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

    logic [EXT-1:0] xe;
    logic [EXT-1:0] ye;
    logic [EXT-1:0] wide;

    // Sign-extend and form the exact sum or difference.
    always_comb begin
        xe   = {x[WIDTH-1], x};
        ye   = {y[WIDTH-1], y};
        wide = sub ? (xe - ye) : (xe + ye);
    end

    // Clamp to the bound on the side of the true sign.
    always_comb begin
        clamped = wide[EXT-1] ^ wide[EXT-2];
        if (clamped)
            sum = wide[EXT-1] ? MINV : MAXV;
        else
            sum = wide[WIDTH-1:0];
    end
endmodule

// File: rtl/q31_sticky_flag.sv
// Sticky saturation record with synchronous active-low reset.
// Clear wins over a same-cycle set; set needs an issued operation.
module q31_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    // Update the sticky bit once per edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (clr_req)
            flag <= 1'b0;
        else if (set_req)
            flag <= 1'b1;
    end
endmodule

// File: rtl/q31_satalu.sv
// Q31 saturating add/subtract unit, top level.
// Result and sat_hit are combinational from opcode and operands;
// only the sticky bit is registered. Doubling forms chain two clamps.
module q31_satalu #(
    parameter int WIDTH = q31_pkg::Q31_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [1:0]       opcode,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             sticky_clr,
    output logic [WIDTH-1:0] result,
    output logic             sat_hit,
    output logic             q_sticky
);
    import q31_pkg::*;

    q31_op_e          op;
    logic [WIDTH-1:0] dbl_val;
    logic             dbl_clamp;
    logic [WIDTH-1:0] second;
    logic             use_dbl;
    logic             fin_clamp;

    // Decode the opcode into stage controls.
    always_comb begin
        op      = q31_op_e'(opcode);
        use_dbl = (op == OP_DADD) || (op == OP_DSUB);
    end

    q31_sat_doubler #(.WIDTH(WIDTH)) u_dbl (
        .din     (opb),
        .dout    (dbl_val),
        .clamped (dbl_clamp)
    );

    // Pick the raw or doubled second operand.
    always_comb second = use_dbl ? dbl_val : opb;

    q31_sat_addsub #(.WIDTH(WIDTH)) u_add (
        .x       (opa),
        .y       (second),
        .sub     (opcode[0]),
        .sum     (result),
        .clamped (fin_clamp)
    );

    // Merge the clamp indications of both stages.
    always_comb sat_hit = fin_clamp | (use_dbl & dbl_clamp);

    q31_sticky_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (issue & sat_hit),
        .clr_req (sticky_clr),
        .flag    (q_sticky)
    );
endmodule

// File: rtl/q31_satalu_chk.sv
// Property checker for q31_satalu, attached by bind.
module q31_satalu_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             issue,
    input logic [1:0]       opcode,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             sticky_clr,
    input logic [WIDTH-1:0] result,
    input logic             sat_hit,
    input logic             q_sticky
);
    localparam logic [WIDTH-1:0] MAXV = {1'b0, {(WIDTH-1){1'b1}}};
    localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

    AST_ADD_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == 2'b00 && opa[WIDTH-1] == opb[WIDTH-1]) |-> (result[WIDTH-1] == opa[WIDTH-1])); // R1
    AST_PLAIN_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (!opcode[1] && sat_hit) |-> (result == MAXV || result == MINV)); // R5
    AST_DBL_MIN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[1] && opb[WIDTH-1] != opb[WIDTH-2]) |-> sat_hit); // R6
    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && sat_hit && !sticky_clr) |=> q_sticky); // R8
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_sticky && !sticky_clr) |=> q_sticky); // R8
    AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_clr |=> !q_sticky); // R9
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_sticky && !(issue && sat_hit)) |=> !q_sticky); // R10
endmodule

bind q31_satalu q31_satalu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
    .opa(opa), .opb(opb), .sticky_clr(sticky_clr), .result(result),
    .sat_hit(sat_hit), .q_sticky(q_sticky)
);

// File: tb/tb_q31_satalu.sv
module tb_q31_satalu;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [1:0]  opcode = 2'b00;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        sticky_clr = 1'b0;
    logic [31:0] result;
    logic        sat_hit;
    logic        q_sticky;

    int total = 0;
    int bad   = 0;
    bit ref_sticky = 1'b0;
    bit finished = 1'b0;

    q31_satalu dut (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .opa(opa), .opb(opb), .sticky_clr(sticky_clr),
        .result(result), .sat_hit(sat_hit), .q_sticky(q_sticky)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint clamp32(longint v);
        if (v > longint'(32'sh7FFFFFFF)) return longint'(32'sh7FFFFFFF);
        if (v < -longint'(64'd2147483648)) return -longint'(64'd2147483648);
        return v;
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check comb outputs, update model at posedge.
    task automatic step(logic [1:0] op, logic [31:0] a, logic [31:0] b,
                        bit iss, bit clr, string req);
        longint sa, sb, d, s, r;
        bit dh, hit;
        @(negedge clk);
        opcode = op; opa = a; opb = b; issue = iss; sticky_clr = clr;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        dh = 1'b0;
        d  = sb;
        if (op[1]) begin
            d  = clamp32(2 * sb);
            dh = (d != 2 * sb);
        end
        s   = op[0] ? sa - d : sa + d;
        r   = clamp32(s);
        hit = dh || (r != s);
        #1;
        check(req, longint'($signed(result)), r);
        check("R7", longint'(sat_hit), longint'(hit));
        @(posedge clk);
        if (!rst_n) ref_sticky = 1'b0;
        else if (clr) ref_sticky = 1'b0;
        else if (iss && hit) ref_sticky = 1'b1;
        #1;
        check("R8/R9/R10 sticky", longint'(q_sticky), longint'(ref_sticky));
    endtask

    function automatic string op_req(logic [1:0] op);
        case (op)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] edges [8];
        edges[0] = 32'h7FFFFFFF; edges[1] = 32'h80000000;
        edges[2] = 32'h7FFFFFFE; edges[3] = 32'h80000001;
        edges[4] = 32'h40000000; edges[5] = 32'hC0000000;
        edges[6] = 32'h00000000; edges[7] = 32'hFFFFFFFF;

        // R11: force the sticky bit high, then reset it.
        rst_n = 1'b1;
        step(2'b00, 32'h7FFFFFFF, 32'h1, 1, 0, "R5");
        rst_n = 1'b0;
        step(2'b00, 32'h0, 32'h0, 0, 0, "R1");
        check("R11 reset", longint'(q_sticky), 0);
        rst_n = 1'b1;

        // R5 and R6 directed corners.
        step(2'b10, 32'h0, 32'h80000000, 0, 0, "R6 dbl min");
        check("R6 value", longint'(result), longint'(32'h80000000));
        step(2'b10, 32'h0, 32'h40000000, 0, 0, "R6 dbl max");
        check("R6 value", longint'(result), longint'(32'h7FFFFFFF));
        step(2'b10, 32'h80000000, 32'h40000000, 0, 0, "R6 hidden clamp");
        check("R6 hit", longint'(sat_hit), 1);
        step(2'b11, 32'h0, 32'h80000000, 0, 0, "R4 R5 both stages");
        step(2'b01, 32'h80000000, 32'h1, 0, 0, "R5 neg");
        step(2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, "R5 pos");
        check("R10 no issue", longint'(q_sticky), 0);

        // R8 set, hold, R9 clear priority.
        step(2'b00, 32'h7FFFFFFF, 32'h1, 1, 0, "R8 set");
        step(2'b00, 32'h1, 32'h1, 1, 0, "R8 hold");
        step(2'b00, 32'h7FFFFFFF, 32'h1, 1, 1, "R9 clr wins");
        check("R9 cleared", longint'(q_sticky), 0);
        step(2'b00, 32'h1, 32'h1, 1, 0, "R1 small");

        // Boundary cross product on every operation.
        for (int o = 0; o < 4; o++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    step(o[1:0], edges[i], edges[j], (i + j) % 3 != 0,
                         (i * j) % 7 == 1, op_req(o[1:0]));

        // Random operands.
        for (int k = 0; k < 4000; k++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 3));
            step(o, $urandom, $urandom, ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 9) == 0), op_req(o));
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule